// File: doc/BRIEF.md
# Bus Traffic Monitor

This block sits next to one bus port and measures how busy that port is. A free-running cycle counter provides the time base. Four event counters count read data beats, write data beats, or both, as reported by one-cycle strobes from the port. Software divides an event count by the cycle count to get the load on the port.

Software controls the block through a small word-addressed register port. Writes take effect on the clock edge on which they are presented. Read data is combinational from the address. A run bit gates every counter. Software starts a measurement by enabling the counters it wants, then writing the run bit with the two clear bits in one write. To take a snapshot, it drops the run bit and reads the frozen values.

The register addresses are: 0 control, 1 enable-set, 2 enable-clear, 3 counter-clear, 4 overflow flags, 5 cycle count, 6 to 8 event counts 0 to 2, 9 event 3 low word, 10 event 3 high word, and 11 to 14 event-type selects 0 to 3.

Top module: `bus_perf_mon`

## Requirements
- R1: After reset, every counter, enable bit, overflow flag, event select and the run bit is 0, so every register reads 0.
- R2: Counter enables use a mask in which bits 3:0 are event counters 0 to 3 and bit 4 is the cycle counter. Writing ones to address 1 sets those bits and writing ones to address 2 clears them. Zero bits leave the mask unchanged. Both addresses read back the current mask.
- R3: In the control register (address 0), bit 0 is run, bit 1 clears all event counters and bit 2 clears the cycle counter. Clears act on the edge of the write, and the same write may also set run. Bits 2:1 always read as 0.
- R4: A counter advances only while run and its own enable bit are both 1. While run is 0, no counter changes except through an explicit clear.
- R5: The cycle counter adds 1 on every counted clock.
- R6: Event select values are 0 for none, 1 for read beats, 2 for write beats and 3 for both. With select 3, a cycle that has a read beat and a write beat adds 2.
- R7: When a counter wraps past its maximum, it continues from zero and sets its overflow flag, which uses the R2 bit position. The flag stays set until software writes a 1 to that bit at address 4. Zero bits leave the flags unchanged.
- R8: Event counter 3 is CNT_W+HI_W bits wide (40 bits by default). Address 9 returns its low CNT_W bits and address 10 returns its upper HI_W bits. The cycle counter and event counters 0 to 2 are CNT_W bits wide.
- R9: Writing ones to the counter-clear register (address 3) clears the counters selected by the R2 mask. That address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational register read data |
| rd_beat | input | 1 | One read data beat on the port this cycle |
| wr_beat | input | 1 | One write data beat on the port this cycle |

## Verification
The event counters are driven with runs of read-only, write-only and simultaneous read-and-write beats, with the four counters set to different select values. This separates select decoding errors from errors in the add-2 case.

Strobes are also driven while run is low and while a single enable bit is off, which shows whether both gates are honoured. A long cycle-count window and a long read burst on counter 3 wrap the narrow words, using a reduced counter width. These runs check the sticky overflow flags and the carry into the high word.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
    localparam int NUM_EV  = 4;
    localparam int SEL_W   = 2;
    localparam int ADDR_W  = 4;
    localparam int MASK_W  = NUM_EV + 1;
    localparam int CYC_BIT = NUM_EV;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_RST  = 4'd3;
    localparam logic [ADDR_W-1:0] A_OVF      = 4'd4;
    localparam logic [ADDR_W-1:0] A_CYC      = 4'd5;
    localparam logic [ADDR_W-1:0] A_EV_BASE  = 4'd6;
    localparam logic [ADDR_W-1:0] A_EV_HI    = A_EV_BASE + ADDR_W'(NUM_EV);
    localparam logic [ADDR_W-1:0] A_SEL_BASE = A_EV_HI + 4'd1;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_EV_RST = 1;
    localparam int CTRL_CY_RST = 2;

    typedef enum logic [SEL_W-1:0] {
        EV_NONE = 2'd0,
        EV_RD   = 2'd1,
        EV_WR   = 2'd2,
        EV_RW   = 2'd3
    } bmon_ev_e;

    typedef struct packed {
        logic                         run;
        logic [MASK_W-1:0]            en;
        logic [MASK_W-1:0]            ovf;
        logic [NUM_EV-1:0][SEL_W-1:0] sel;
    } bmon_state_t;
endpackage

// File: rtl/bmon_evsel.sv
module bmon_evsel
    import bmon_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             rd,
    input  logic             wr,
    output logic [1:0]       inc
);
    always_comb begin
        unique case (bmon_ev_e'(sel))
            EV_RD:   inc = {1'b0, rd};
            EV_WR:   inc = {1'b0, wr};
            EV_RW:   inc = {1'b0, rd} + {1'b0, wr};
            default: inc = 2'd0;
        endcase
    end
endmodule

// File: rtl/bmon_ctr.sv
module bmon_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [1:0]   inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   sum;

    assign sum = {1'b0, cnt_q} + (W+1)'(inc);

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = sum[W-1:0];
            wrap  = sum[W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bus_perf_mon.sv
module bus_perf_mon
    import bmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int HI_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat
);
    localparam int WIDE = CNT_W + HI_W;

    bmon_state_t st_d, st_q;

    logic                        wr_ctrl, wr_en_set, wr_en_clr, wr_cnt_rst, wr_ovf;
    logic [MASK_W-1:0]           wmask;
    logic                        cyc_clr, cyc_wrap;
    logic [CNT_W-1:0]            cyc_cnt;
    logic [NUM_EV-1:0]           ev_clr, ev_wrap;
    logic [NUM_EV-1:0][WIDE-1:0] ev_cnt;
    logic                        unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wmask        = reg_wdata[MASK_W-1:0];
    assign wr_ctrl      = reg_wr && (reg_addr == A_CTRL);
    assign wr_en_set    = reg_wr && (reg_addr == A_EN_SET);
    assign wr_en_clr    = reg_wr && (reg_addr == A_EN_CLR);
    assign wr_cnt_rst   = reg_wr && (reg_addr == A_CNT_RST);
    assign wr_ovf       = reg_wr && (reg_addr == A_OVF);

    assign cyc_clr = (wr_ctrl && reg_wdata[CTRL_CY_RST]) || (wr_cnt_rst && wmask[CYC_BIT]);

    bmon_ctr #(.W(CNT_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cyc_clr),
        .en    (st_q.run && st_q.en[CYC_BIT]),
        .inc   (2'd1),
        .cnt   (cyc_cnt),
        .wrap  (cyc_wrap)
    );

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        localparam int W = (i == NUM_EV - 1) ? WIDE : CNT_W;
        logic [1:0]   inc;
        logic [W-1:0] cnt;

        assign ev_clr[i] = (wr_ctrl && reg_wdata[CTRL_EV_RST]) || (wr_cnt_rst && wmask[i]);

        bmon_evsel u_sel (
            .sel (st_q.sel[i]),
            .rd  (rd_beat),
            .wr  (wr_beat),
            .inc (inc)
        );

        bmon_ctr #(.W(W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (ev_clr[i]),
            .en    (st_q.run && st_q.en[i]),
            .inc   (inc),
            .cnt   (cnt),
            .wrap  (ev_wrap[i])
        );

        assign ev_cnt[i] = WIDE'(cnt);
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)   st_d.run = reg_wdata[CTRL_RUN];
        if (wr_en_set) st_d.en  = st_q.en | wmask;
        if (wr_en_clr) st_d.en  = st_q.en & ~wmask;
        st_d.ovf = (st_q.ovf & ~(wr_ovf ? wmask : '0)) | {cyc_wrap, ev_wrap};
        for (int i = 0; i < NUM_EV; i++) begin
            if (reg_wr && (reg_addr == A_SEL_BASE + ADDR_W'(i)))
                st_d.sel[i] = reg_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:              reg_rdata = DATA_W'(st_q.run);
            A_EN_SET, A_EN_CLR:  reg_rdata = DATA_W'(st_q.en);
            A_OVF:               reg_rdata = DATA_W'(st_q.ovf);
            A_CYC:               reg_rdata = DATA_W'(cyc_cnt);
            A_EV_HI:             reg_rdata = DATA_W'(ev_cnt[NUM_EV-1][WIDE-1:CNT_W]);
            default:             reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_EV; i++) begin
            if (reg_addr == A_EV_BASE + ADDR_W'(i))
                reg_rdata = DATA_W'(ev_cnt[i][CNT_W-1:0]);
            if (reg_addr == A_SEL_BASE + ADDR_W'(i))
                reg_rdata = DATA_W'(st_q.sel[i]);
        end
    end
endmodule

// File: rtl/bmon_checker.sv
module bmon_checker
    import bmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int WIDE   = 40
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W-1:0]           reg_rdata,
    input logic                        run_q,
    input logic [MASK_W-1:0]           en_q,
    input logic [MASK_W-1:0]           ovf_q,
    input logic                        cyc_clr,
    input logic [NUM_EV-1:0]           ev_clr,
    input logic [CNT_W-1:0]            cyc_cnt,
    input logic [NUM_EV-1:0][WIDE-1:0] ev_cnt
);
    logic ovf_wr;
    assign ovf_wr = reg_wr && (reg_addr == A_OVF);

    p_ctrl_rdbk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (reg_rdata[2:1] == 2'b00));

    p_cyc_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cyc_clr) |=> $stable(cyc_cnt));

    p_ev_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && (ev_clr == '0)) |=> $stable(ev_cnt));

    p_cyc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en_q[CYC_BIT] && !cyc_clr) |=> (cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1)));

    p_ev_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_clr[0] |=> (CNT_W'(ev_cnt[0][CNT_W-1:0] - $past(ev_cnt[0][CNT_W-1:0])) <= CNT_W'(2)));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_wr |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
endmodule

bind bus_perf_mon bmon_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .WIDE   (WIDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .run_q     (st_q.run),
    .en_q      (st_q.en),
    .ovf_q     (st_q.ovf),
    .cyc_clr   (cyc_clr),
    .ev_clr    (ev_clr),
    .cyc_cnt   (cyc_cnt),
    .ev_cnt    (ev_cnt)
);

// File: tb/sim_bus_perf_mon.sv
`timescale 1ns/1ps
module sim_bus_perf_mon;
    localparam int DW = 32;
    localparam int CW = 8;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          rd_beat = 1'b0;
    logic          wr_beat = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_perf_mon #(.DATA_W(DW), .CNT_W(CW), .HI_W(HW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rd_beat   (rd_beat),
        .wr_beat   (wr_beat)
    );

    task automatic wreg(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk(input string req, input logic [3:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] got;
        @(negedge clk);
        reg_addr = a;
        #1;
        got = reg_rdata;
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d: actual 0x%0h expected 0x%0h", req, a, got, exp);
        end
    endtask

    task automatic drive(input logic r, input logic w, input int n);
        rd_beat = r; wr_beat = w;
        repeat (n) @(posedge clk);
        @(negedge clk);
        rd_beat = 1'b0; wr_beat = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 15; a++) chk("R1", 4'(a), '0);
    endtask

    task automatic t_enables();
        wreg(4'd1, 32'h05); chk("R2", 4'd1, 32'h05);
        wreg(4'd1, 32'h02); chk("R2", 4'd2, 32'h07);
        wreg(4'd2, 32'h01); chk("R2", 4'd1, 32'h06);
        wreg(4'd2, 32'h00); chk("R2", 4'd2, 32'h06);
        wreg(4'd1, 32'h1F); chk("R2", 4'd1, 32'h1F);
    endtask

    task automatic t_cycle();
        wreg(4'd0, 32'h7);
        repeat (20) @(posedge clk);
        wreg(4'd0, 32'h0);
        chk("R5", 4'd5, 32'd21);
    endtask

    task automatic t_select();
        wreg(4'd11, 32'd1);
        wreg(4'd12, 32'd2);
        wreg(4'd13, 32'd3);
        wreg(4'd14, 32'd0);
        wreg(4'd0, 32'h7);
        drive(1'b1, 1'b0, 5);
        drive(1'b0, 1'b1, 3);
        drive(1'b1, 1'b1, 4);
        wreg(4'd0, 32'h0);
        chk("R6 read", 4'd6, 32'd9);
        chk("R6 write", 4'd7, 32'd7);
        chk("R6 both", 4'd8, 32'd16);
        chk("R6 none", 4'd9, 32'd0);
        chk("R6 sel", 4'd13, 32'd3);
    endtask

    task automatic t_freeze();
        logic [DW-1:0] cyc_before;
        @(negedge clk); reg_addr = 4'd5; #1; cyc_before = reg_rdata;
        drive(1'b1, 1'b1, 10);
        chk("R4 run off", 4'd6, 32'd9);
        chk("R4 run off", 4'd8, 32'd16);
        chk("R4 run off cyc", 4'd5, cyc_before);
        wreg(4'd2, 32'h02);
        wreg(4'd0, 32'h1);
        drive(1'b1, 1'b1, 4);
        wreg(4'd0, 32'h0);
        chk("R4 enabled", 4'd6, 32'd13);
        chk("R4 enable off", 4'd7, 32'd7);
        chk("R4 enabled both", 4'd8, 32'd24);
    endtask

    task automatic t_ctrl();
        wreg(4'd0, 32'h7);
        chk("R3 readback", 4'd0, 32'h1);
        chk("R3 ev clear", 4'd6, 32'd0);
        wreg(4'd0, 32'h6);
        chk("R3 readback", 4'd0, 32'h0);
        chk("R3 cyc clear", 4'd5, 32'd0);
    endtask

    task automatic t_cnt_rst();
        wreg(4'd1, 32'h1F);
        wreg(4'd0, 32'h7);
        drive(1'b1, 1'b0, 6);
        wreg(4'd0, 32'h0);
        chk("R9 pre", 4'd6, 32'd6);
        wreg(4'd3, 32'h01);
        chk("R9 cleared", 4'd6, 32'd0);
        chk("R9 kept", 4'd8, 32'd6);
        chk("R9 readback", 4'd3, 32'd0);
    endtask

    task automatic t_overflow();
        wreg(4'd4, 32'h1F);
        chk("R7 flags clear", 4'd4, 32'd0);
        wreg(4'd0, 32'h5);
        repeat (259) @(posedge clk);
        wreg(4'd0, 32'h0);
        chk("R7 wrapped", 4'd5, 32'd4);
        chk("R7 flag", 4'd4, 32'h10);
        wreg(4'd4, 32'h0F);
        chk("R7 sticky", 4'd4, 32'h10);
        wreg(4'd4, 32'h10);
        chk("R7 w1c", 4'd4, 32'h00);
    endtask

    task automatic t_wide();
        logic [DW-1:0] f;
        wreg(4'd14, 32'd1);
        wreg(4'd0, 32'h3);
        drive(1'b1, 1'b0, 300);
        wreg(4'd0, 32'h0);
        chk("R8 low", 4'd9, 32'd44);
        chk("R8 high", 4'd10, 32'd1);
        @(negedge clk); reg_addr = 4'd4; #1; f = reg_rdata;
        n_chk++;
        if (f[3] !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 no overflow: actual %0b expected 0", f[3]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enables();
        t_cycle();
        t_select();
        t_freeze();
        t_ctrl();
        t_cnt_rst();
        t_overflow();
        t_wide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule